// File: doc/BRIEF.md
# Paged CPU Memory Access Decoder

This block connects an 8-bit processor bus to six internal memories through one 128-byte window. Address bit 7 picks the space. When it is low, the access goes to control-register space. When it is high, the access goes through the memory window. One writable page byte holds two fields: a 3-bit memory select and a 5-bit page number. For a window access, the block places the page above the seven low address lines to form a 12-bit memory address. It then sends the access to the selected memory port.

The six memory ports are receive connection low, receive connection high, receive data, transmit connection low, transmit connection high and transmit data. Two of the select codes choose no memory. Instead they arm a block-programming mode for one of the connection-high memories. In that mode, window writes come out on a dedicated strobe, and no memory sees them. A rate-mode input limits how many page bits are used, so the address stays inside the channel count of the current mode.

The software must write the page byte before it makes any window access.

Top module: `cpu_page_decoder`

## Requirements
- R1: After reset the page byte is 0x00. It reads back as 0x00 at control offset 0, no write strobe is active, and block-programming mode is off.
- R2: A write to control offset 0 (address 0x00) stores the byte. A read of offset 0 returns exactly that byte. The other control offsets (0x01–0x7F) read 0x00, and writes to them change nothing.
- R3: The page byte is decoded as follows. The select code is {bit2, bit7, bit6}. The page is {bit5, bit4, bit1, bit3, bit0}, from the most significant page bit down to the least.
- R4: Select codes map to ports as follows: 000→0 (rx conn low), 001→1 (rx conn high), 010→2 (rx data), 100→3 (tx conn low), 101→4 (tx conn high), 110→5 (tx data). A window read raises only that port's read strobe. In the same cycle it returns byte k of mem_rdata_i (bits 8k+7..8k) for port k.
- R5: The window address is {page, address[6:0]}. It appears on mem_raddr_o in the same cycle for reads, and on mem_waddr_o for writes.
- R6: A window write gives a one-cycle, one-hot mem_we_o pulse on the selected port. The pulse comes in the cycle after the bus write, together with the registered address and data.
- R7: Select codes 011 and 111 set blk_prog_o. blk_tx_o is 0 for 011 and 1 for 111. In this mode a window write gives a one-cycle blk_wr_o pulse in the cycle after the write, and no mem_we_o. A window read returns 0x00 and raises no read strobe.
- R8: Rate mode 0 or 3 uses all five page bits (12-bit address). Mode 1 forces address bit 11 to zero. Mode 2 forces address bits 11:10 to zero.
- R9: Accesses to control space raise no memory read strobe and no memory write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_cs_i | input | 1 | Bus access strobe, one cycle per access |
| cpu_wr_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 8 | Bus address; bit 7 selects the window |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data, valid in the access cycle |
| rate_mode_i | input | 2 | Channel-count mode for address range |
| mem_raddr_o | output | 12 | Read address, combinational |
| mem_re_o | output | 6 | One-hot read strobes |
| mem_rdata_i | input | 48 | Read data, byte k from port k |
| mem_waddr_o | output | 12 | Registered write address |
| mem_wdata_o | output | 8 | Registered write data |
| mem_we_o | output | 6 | One-hot write pulses |
| blk_prog_o | output | 1 | Block-programming mode active |
| blk_tx_o | output | 1 | Block-programming target: 0 receive, 1 transmit |
| blk_wr_o | output | 1 | Window write captured in block mode |

## Verification
Read results are combinational. The read data, the read strobe and the read address are all due in the access cycle, so the bench samples them one time unit after driving the inputs on the falling edge, before the next rising edge. Write results pass through one register. mem_we_o, blk_wr_o, the write address and the write data are therefore checked on the falling edge that follows the capturing rising edge, and checked again one cycle later to confirm that the pulse has ended. A page-byte write takes effect at that same capturing edge, so any read that depends on it is issued afterwards.

// File: rtl/cpu_page_pkg.sv
package cpu_page_pkg;
  localparam int DATA_W = 8;
  localparam int LOW_W  = 7;
  localparam int PAGE_W = 5;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = PAGE_W + LOW_W;
  localparam int N_MEM  = 6;
  localparam int IDX_W  = $clog2(N_MEM);

  typedef enum logic [SEL_W-1:0] {
    SEL_RX_CLO = 3'b000, SEL_RX_CHI = 3'b001, SEL_RX_DAT = 3'b010, SEL_RX_BLK = 3'b011,
    SEL_TX_CLO = 3'b100, SEL_TX_CHI = 3'b101, SEL_TX_DAT = 3'b110, SEL_TX_BLK = 3'b111
  } mem_sel_e;

  typedef enum logic [1:0] {
    RATE_FULL = 2'd0, RATE_MID = 2'd1, RATE_LOW = 2'd2, RATE_ALT = 2'd3
  } rate_e;
endpackage

// File: rtl/cpu_page_reg.sv
module cpu_page_reg
  import cpu_page_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] byte_o,
  output mem_sel_e          sel_o,
  output logic [PAGE_W-1:0] page_o
);
  logic [DATA_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (wr_en_i) q <= wdata_i;
  end

  assign byte_o = q;
  // interleaved field layout decoded by software
  assign sel_o  = mem_sel_e'({q[2], q[7], q[6]});
  assign page_o = {q[5], q[4], q[1], q[3], q[0]};

  a_r2_reg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> byte_o == $past(wdata_i));
  a_r2_reg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(byte_o));
endmodule

// File: rtl/cpu_page_addr.sv
module cpu_page_addr
  import cpu_page_pkg::*;
(
  input  logic [PAGE_W-1:0] page_i,
  input  logic [LOW_W-1:0]  low_i,
  input  rate_e             rate_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [1:0]        drop;
  logic [ADDR_W-1:0] mask;

  always_comb begin
    unique case (rate_i)
      RATE_MID: drop = 2'd1;
      RATE_LOW: drop = 2'd2;
      default:  drop = 2'd0;
    endcase
  end

  assign mask   = {ADDR_W{1'b1}} >> drop;
  assign addr_o = {page_i, low_i} & mask;
endmodule

// File: rtl/cpu_page_route.sv
module cpu_page_route
  import cpu_page_pkg::*;
(
  input  logic                    cs_i,
  input  logic                    wr_i,
  input  logic                    win_i,
  input  logic                    ctrl_hit_i,
  input  logic [DATA_W-1:0]       ctrl_byte_i,
  input  mem_sel_e                sel_i,
  input  logic [N_MEM*DATA_W-1:0] mem_rdata_i,
  output logic [N_MEM-1:0]        re_o,
  output logic [N_MEM-1:0]        we_o,
  output logic                    blk_o,
  output logic                    blk_wr_o,
  output logic [DATA_W-1:0]       rdata_o
);
  logic [IDX_W-1:0] idx;
  logic [N_MEM-1:0] hit;
  logic             win_acc;

  assign blk_o   = (sel_i[1:0] == 2'b11);
  assign idx     = IDX_W'(sel_i[2] ? 3 : 0) + IDX_W'(sel_i[1:0]);
  assign win_acc = cs_i & win_i & ~blk_o;

  for (genvar g = 0; g < N_MEM; g++) begin : g_hit
    assign hit[g] = (idx == IDX_W'(g));
  end

  assign re_o     = (win_acc & ~wr_i) ? hit : '0;
  assign we_o     = (win_acc &  wr_i) ? hit : '0;
  assign blk_wr_o = cs_i & win_i & wr_i & blk_o;

  always_comb begin
    rdata_o = '0;
    if (cs_i && !wr_i) begin
      if (win_i) begin
        if (!blk_o) rdata_o = mem_rdata_i[idx*DATA_W +: DATA_W];
      end else if (ctrl_hit_i) begin
        rdata_o = ctrl_byte_i;
      end
    end
  end
endmodule

// File: rtl/cpu_page_decoder.sv
module cpu_page_decoder
  import cpu_page_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cpu_cs_i,
  input  logic        cpu_wr_i,
  input  logic [7:0]  cpu_addr_i,
  input  logic [7:0]  cpu_wdata_i,
  output logic [7:0]  cpu_rdata_o,
  input  logic [1:0]  rate_mode_i,
  output logic [11:0] mem_raddr_o,
  output logic [5:0]  mem_re_o,
  input  logic [47:0] mem_rdata_i,
  output logic [11:0] mem_waddr_o,
  output logic [7:0]  mem_wdata_o,
  output logic [5:0]  mem_we_o,
  output logic        blk_prog_o,
  output logic        blk_tx_o,
  output logic        blk_wr_o
);
  logic              win, ctrl_hit, reg_we;
  logic [DATA_W-1:0] reg_byte;
  mem_sel_e          sel;
  logic [PAGE_W-1:0] page;
  logic [ADDR_W-1:0] addr;
  logic [N_MEM-1:0]  we_d;
  logic              blk_wr_d;

  assign win      = cpu_addr_i[DATA_W-1];
  assign ctrl_hit = (cpu_addr_i[LOW_W-1:0] == '0);
  assign reg_we   = cpu_cs_i & cpu_wr_i & ~win & ctrl_hit;

  cpu_page_reg u_reg (
    .clk_i, .rst_ni, .wr_en_i(reg_we), .wdata_i(cpu_wdata_i),
    .byte_o(reg_byte), .sel_o(sel), .page_o(page)
  );

  cpu_page_addr u_addr (
    .page_i(page), .low_i(cpu_addr_i[LOW_W-1:0]), .rate_i(rate_e'(rate_mode_i)), .addr_o(addr)
  );

  cpu_page_route u_route (
    .cs_i(cpu_cs_i), .wr_i(cpu_wr_i), .win_i(win), .ctrl_hit_i(ctrl_hit),
    .ctrl_byte_i(reg_byte), .sel_i(sel), .mem_rdata_i,
    .re_o(mem_re_o), .we_o(we_d), .blk_o(blk_prog_o), .blk_wr_o(blk_wr_d),
    .rdata_o(cpu_rdata_o)
  );

  assign blk_tx_o    = sel[2];
  assign mem_raddr_o = addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= '0;
      blk_wr_o    <= 1'b0;
      mem_waddr_o <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= we_d;
      blk_wr_o <= blk_wr_d;
      if (cpu_cs_i && cpu_wr_i && win) begin
        mem_waddr_o <= addr;
        mem_wdata_o <= cpu_wdata_i;
      end
    end
  end

  a_r6_we_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mem_we_o));
  a_r6_we_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_cs_i && cpu_wr_i && win && !blk_prog_o) |=> $countones(mem_we_o) == 1);
  a_r7_blk_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_wr_o |-> mem_we_o == '0);
  a_r7_blk_no_re: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_prog_o |-> mem_re_o == '0);
  a_r8_low_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_mode_i == 2'd2) |-> mem_raddr_o[11:10] == 2'b00);
  a_r9_ctrl_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_cs_i && !win) |=> mem_we_o == '0 && !blk_wr_o);
endmodule

// File: tb/cpu_page_decoder_test.sv
module cpu_page_decoder_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [1:0]  rate = 2'd0;
  logic [47:0] mrd;
  logic [7:0]  rdata, mwdata;
  logic [11:0] raddr, waddr;
  logic [5:0]  re, we;
  logic        bprog, btx, bwr;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  for (genvar k = 0; k < 6; k++) begin : g_md
    assign mrd[k*8 +: 8] = 8'hA0 + 8'(k);
  end

  cpu_page_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_cs_i(cs), .cpu_wr_i(wr), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .rate_mode_i(rate), .mem_raddr_o(raddr),
    .mem_re_o(re), .mem_rdata_i(mrd), .mem_waddr_o(waddr), .mem_wdata_o(mwdata),
    .mem_we_o(we), .blk_prog_o(bprog), .blk_tx_o(btx), .blk_wr_o(bwr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pack(logic [2:0] s, logic [4:0] p);
    return {s[1], s[0], p[4], p[3], p[1], s[2], p[2], p[0]};
  endfunction

  // drives a one-cycle write; returns on the falling edge after capture
  task automatic bus_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; wr = 0; addr = a;
    #1 d = rdata;
    cs = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 we", 32'(we), 0);
    chk("R1 blk", 32'(bprog), 0);
    bus_rd(8'h00, d);
    chk("R1 reg", 32'(d), 0);
  endtask

  task automatic t_reg();
    logic [7:0] d;
    bus_wr(8'h00, 8'hA5);
    chk("R9 no we", 32'(we), 0);
    bus_rd(8'h00, d); chk("R2 readback", 32'(d), 32'hA5);
    bus_wr(8'h05, 8'h3C);
    bus_rd(8'h00, d); chk("R2 other offset write ignored", 32'(d), 32'hA5);
    bus_rd(8'h05, d); chk("R2 other offset reads 0", 32'(d), 0);
    @(negedge clk); cs = 1; wr = 0; addr = 8'h00;
    #1 chk("R9 no re", 32'(re), 0);
    cs = 0;
  endtask

  task automatic t_select();
    logic [2:0] codes [6] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110};
    rate = 2'd0;
    for (int k = 0; k < 6; k++) begin
      bus_wr(8'h00, pack(codes[k], 5'h15));
      @(negedge clk); cs = 1; wr = 0; addr = 8'hA3;
      #1;
      chk("R4 re onehot", 32'(re), 32'(6'b1 << k));
      chk("R4 rdata", 32'(rdata), 32'(8'hA0 + 8'(k)));
      chk("R5 R3 raddr", 32'(raddr), 32'h0AA3);
      cs = 0;
    end
  endtask

  task automatic t_write();
    bus_wr(8'h00, pack(3'b101, 5'h1F));
    bus_wr(8'hFF, 8'h5A);
    chk("R6 we", 32'(we), 32'h10);
    chk("R6 waddr", 32'(waddr), 32'hFFF);
    chk("R6 wdata", 32'(mwdata), 32'h5A);
    @(negedge clk);
    chk("R6 pulse ends", 32'(we), 0);
  endtask

  task automatic t_blk();
    logic [7:0] d;
    bus_wr(8'h00, pack(3'b011, 5'h02));
    chk("R7 blk on", 32'(bprog), 1);
    chk("R7 rx target", 32'(btx), 0);
    bus_wr(8'h81, 8'h77);
    chk("R7 blk_wr", 32'(bwr), 1);
    chk("R7 no we", 32'(we), 0);
    @(negedge clk);
    chk("R7 blk_wr ends", 32'(bwr), 0);
    @(negedge clk); cs = 1; wr = 0; addr = 8'h81;
    #1 chk("R7 read zero", 32'(rdata), 0);
    chk("R7 no re", 32'(re), 0);
    cs = 0;
    bus_wr(8'h00, pack(3'b111, 5'h00));
    chk("R7 tx target", 32'(btx), 1);
    chk("R7 blk on tx", 32'(bprog), 1);
    bus_rd(8'h00, d); chk("R2 readback blk", 32'(d), 32'(pack(3'b111, 5'h00)));
  endtask

  task automatic t_rate();
    bus_wr(8'h00, pack(3'b010, 5'h1F));
    for (int m = 0; m < 4; m++) begin
      logic [11:0] e;
      e = (m == 1) ? 12'h7FF : (m == 2) ? 12'h3FF : 12'hFFF;
      @(negedge clk); rate = 2'(m); cs = 1; wr = 0; addr = 8'hFF;
      #1 chk("R8 raddr", 32'(raddr), 32'(e));
      cs = 0;
    end
    rate = 2'd0;
  endtask

  initial begin : watchdog
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_reg();
    t_select();
    t_write();
    t_blk();
    t_rate();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule